// File: doc/BRIEF.md
# Banked Data-Memory Address Front End

This block sits between the operand fields of a small 8-bit core and its register file. It turns each access into a physical location in a four-bank, 512-entry byte store. The access comes either as a 7-bit direct offset taken from an instruction or, through a reserved offset, as an 8-bit pointer. The block owns two core registers that are visible from every bank. The first is a control byte whose top three bits steer banking. The second is the pointer used for indirect access.

A direct access takes its bank from a two-bit field of the control byte. An indirect access takes the bank pair from the control byte's top bit and the bank within that pair from the pointer's top bit. A window at the top of every bank always lands in bank 0, so values placed there are shared whatever the bank selection. Reads are registered and come out one cycle after the strobe. A reset clears the control byte only. The pointer and all general storage keep their contents, so the store can be built from plain block RAM.

Top module: `banked_regfile`

## Requirements
- R1: A direct access at an offset from 0x05 to 0x6F reaches physical location {ctrl[6:5], offset}, where ctrl[6:5] is the bank field (00 = bank 0 ... 11 = bank 3) and locations in different banks are independent.
- R2: Offsets 0x70 to 0x7F reach physical location {00, offset} whatever the bank field, so a value written there under one bank reads back under every other bank.
- R3: The control byte at offset 0x03 and the pointer at offset 0x04 are read and written from every bank, and a control write changes the bank used from the next access on.
- R4: A direct access at offset 0x00 is redirected to pointer-selected location {ctrl[7], ptr[7:0]}, that is, bank {ctrl[7], ptr[7]} and offset ptr[6:0]. This target is then mapped like a direct offset: the common window goes to bank 0, and offsets 0x03 and 0x04 reach the control byte and the pointer.
- R5: When the redirected offset ptr[6:0] is 0x00, a read returns 0x00 and a write changes nothing.
- R6: rd_data shows the read value one cycle after rd_en. It holds its value while rd_en is low. A read and a write to the same location in one cycle return the contents from before the write.
- R7: rst clears the control byte to 0x00 and rd_data to 0x00. The pointer and general storage keep their contents across reset.
- R8: Control bits [4:0] carry no banking meaning and read back exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 7 | Direct offset; 0x00 selects the pointer target |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |

## Verification
Every cycle, the assertions check where a write is steered for plain, common-window and pointer-based offsets. They also check that the null pointer target blocks every write and reads as zero, that at most one destination is written, that rd_data and the pointer stay put when nothing asks them to change, and that the control byte is cleared when reset ends. Only the bench's scenarios can show that the steering keeps the data. That covers values staying separate between banks, the common window reading the same byte under all four banks, and indirect reads returning what direct writes stored. It also covers read-first ordering and storage surviving a reset.

// File: rtl/bankfile_pkg.sv
package bankfile_pkg;
  // Destination of one access after address translation.
  typedef enum logic [1:0] {
    TGT_NULL   = 2'd0,
    TGT_RAM    = 2'd1,
    TGT_CTRL   = 2'd2,
    TGT_PTR    = 2'd3
  } tgt_t;
endpackage

// File: rtl/bank_addr_map.sv
module bank_addr_map
  import bankfile_pkg::*;
#(
  parameter int OFFS_W    = 7,
  parameter int DATA_W    = 8,
  parameter int COMMON_LO = 'h70,
  parameter int CTRL_OFS  = 'h03,
  parameter int PTR_OFS   = 'h04,
  parameter int BANK_LSB  = 5,
  parameter int PAIR_BIT  = 7
) (
  input  logic [OFFS_W-1:0]   addr,
  input  logic [DATA_W-1:0]   ctrl,
  input  logic [DATA_W-1:0]   ptr,
  output tgt_t                tgt,
  output logic [OFFS_W+1:0]   phys
);
  localparam int BANK_W = 2;
  localparam logic [OFFS_W-1:0] C_LO   = OFFS_W'(COMMON_LO);
  localparam logic [OFFS_W-1:0] C_CTRL = OFFS_W'(CTRL_OFS);
  localparam logic [OFFS_W-1:0] C_PTR  = OFFS_W'(PTR_OFS);

  logic              via_ptr;
  logic [BANK_W-1:0] bank;
  logic [OFFS_W-1:0] offs;

  always_comb begin
    via_ptr = (addr == '0);
    if (via_ptr) begin
      bank = {ctrl[PAIR_BIT], ptr[DATA_W-1]};
      offs = ptr[OFFS_W-1:0];
    end else begin
      bank = ctrl[BANK_LSB +: BANK_W];
      offs = addr;
    end

    if (offs == '0)          tgt = TGT_NULL;
    else if (offs == C_CTRL) tgt = TGT_CTRL;
    else if (offs == C_PTR)  tgt = TGT_PTR;
    else                     tgt = TGT_RAM;

    if (offs >= C_LO) phys = {{BANK_W{1'b0}}, offs};
    else              phys = {bank, offs};
  end
endmodule

// File: rtl/bank_core_regs.sv
module bank_core_regs #(
  parameter int DATA_W   = 8,
  parameter int CTRL_RST = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic              ptr_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] ptr_q
);
  localparam logic [DATA_W-1:0] CTRL_INIT = DATA_W'(CTRL_RST);

  // Control byte: defined value on reset.
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= CTRL_INIT;
    else if (ctrl_we) ctrl_q <= wdata;
  end

  // Pointer: power-up value only, untouched by reset.
  logic [DATA_W-1:0] ptr_r = '0;
  always_ff @(posedge clk) begin
    if (ptr_we) ptr_r <= wdata;
  end
  assign ptr_q = ptr_r;

  assert_ctrl_reset_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (ctrl_q == CTRL_INIT));
endmodule

// File: rtl/bank_ram.sv
module bank_ram #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read-first: a same-cycle write is seen on the next read.
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import bankfile_pkg::*;
#(
  parameter int OFFS_W    = 7,
  parameter int DATA_W    = 8,
  parameter int COMMON_LO = 'h70,
  parameter int CTRL_OFS  = 'h03,
  parameter int PTR_OFS   = 'h04,
  parameter int BANK_LSB  = 5,
  parameter int PAIR_BIT  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [OFFS_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PHYS_W = OFFS_W + 2;
  localparam logic [OFFS_W-1:0] C_LO   = OFFS_W'(COMMON_LO);
  localparam logic [OFFS_W-1:0] C_CTRL = OFFS_W'(CTRL_OFS);
  localparam logic [OFFS_W-1:0] C_PTR  = OFFS_W'(PTR_OFS);

  logic [DATA_W-1:0] ctrl, ptr;
  tgt_t              tgt;
  logic [PHYS_W-1:0] phys;

  bank_addr_map #(
    .OFFS_W(OFFS_W), .DATA_W(DATA_W), .COMMON_LO(COMMON_LO),
    .CTRL_OFS(CTRL_OFS), .PTR_OFS(PTR_OFS),
    .BANK_LSB(BANK_LSB), .PAIR_BIT(PAIR_BIT)
  ) u_map (
    .addr(addr), .ctrl(ctrl), .ptr(ptr), .tgt(tgt), .phys(phys)
  );

  logic ram_we, ctrl_we, ptr_we;
  assign ram_we  = wr_en && (tgt == TGT_RAM);
  assign ctrl_we = wr_en && (tgt == TGT_CTRL);
  assign ptr_we  = wr_en && (tgt == TGT_PTR);

  bank_core_regs #(.DATA_W(DATA_W), .CTRL_RST(0)) u_regs (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ptr_we(ptr_we),
    .wdata(wr_data), .ctrl_q(ctrl), .ptr_q(ptr)
  );

  logic [DATA_W-1:0] ram_q;
  bank_ram #(.ADDR_W(PHYS_W), .DATA_W(DATA_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(phys), .wdata(wr_data),
    .re(rd_en && (tgt == TGT_RAM)), .raddr(phys), .rdata(ram_q)
  );

  // Registered read path for the core registers and the null target.
  tgt_t              rd_tgt_q;
  logic [DATA_W-1:0] spec_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_tgt_q <= TGT_NULL;
      spec_q   <= '0;
    end else if (rd_en) begin
      rd_tgt_q <= tgt;
      spec_q   <= (tgt == TGT_CTRL) ? ctrl : ptr;
    end
  end

  always_comb begin
    case (rd_tgt_q)
      TGT_RAM:  rd_data = ram_q;
      TGT_NULL: rd_data = '0;
      default:  rd_data = spec_q;
    endcase
  end

  // ---------------- assertions ----------------
  assert_direct_bank_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr > C_PTR && addr < C_LO) |->
      (ram_we && phys == {ctrl[BANK_LSB +: 2], addr}));

  assert_common_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr >= C_LO) |->
      (ram_we && phys[PHYS_W-1:OFFS_W] == 2'b00 && phys[OFFS_W-1:0] == addr));

  assert_ctrl_write_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == C_CTRL) |=> (ctrl == $past(wr_data)));

  assert_indirect_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && ptr[OFFS_W-1:0] > C_PTR && ptr[OFFS_W-1:0] < C_LO) |->
      (ram_we && phys == {ctrl[PAIR_BIT], ptr}));

  assert_single_dest_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_we, ctrl_we, ptr_we}));

  assert_null_write_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == '0 && ptr[OFFS_W-1:0] == '0) |->
      (!ram_we && !ctrl_we && !ptr_we));

  assert_null_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == '0 && ptr[OFFS_W-1:0] == '0) |=> (rd_data == '0));

  assert_rd_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  assert_ptr_keep_R7: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(ptr));
endmodule

// File: tb/banked_regfile_bench.sv
module banked_regfile_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [6:0] addr = '0;
  logic       rd_en = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  banked_regfile u_banked_regfile (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  // Vector: {is_write, offset, data or expected, requirement number}
  // Control byte at 0x03: [7] pair select, [6:5] bank, [4:0] plain bits.
  localparam int NV = 50;
  localparam logic [19:0] VEC [NV] = '{
    // R1: one offset in each of the four banks
    {1'b1,7'h03,8'h00,4'd1}, {1'b1,7'h20,8'h11,4'd1},
    {1'b1,7'h03,8'h20,4'd1}, {1'b1,7'h20,8'h22,4'd1},
    {1'b1,7'h03,8'h40,4'd1}, {1'b1,7'h20,8'h33,4'd1},
    {1'b1,7'h03,8'h60,4'd1}, {1'b1,7'h20,8'h44,4'd1},
    {1'b0,7'h20,8'h44,4'd1}, {1'b1,7'h03,8'h00,4'd1},
    {1'b0,7'h20,8'h11,4'd1}, {1'b1,7'h03,8'h20,4'd1},
    {1'b0,7'h20,8'h22,4'd1}, {1'b1,7'h03,8'h40,4'd1},
    {1'b0,7'h20,8'h33,4'd1},
    // R2: common window written in bank 2, read in banks 3 and 0
    {1'b1,7'h75,8'hA5,4'd2}, {1'b1,7'h03,8'h60,4'd2},
    {1'b0,7'h75,8'hA5,4'd2}, {1'b1,7'h03,8'h00,4'd2},
    {1'b0,7'h75,8'hA5,4'd2},
    // R3: control readable, reaches pair 1 / bank 3
    {1'b0,7'h03,8'h00,4'd3}, {1'b1,7'h03,8'hE0,4'd3},
    {1'b0,7'h03,8'hE0,4'd3},
    // R4: indirect reads, both pairs, both halves
    {1'b1,7'h04,8'hA0,4'd4}, {1'b0,7'h00,8'h44,4'd4},
    {1'b1,7'h04,8'h20,4'd4}, {1'b0,7'h00,8'h33,4'd4},
    {1'b1,7'h03,8'h00,4'd4}, {1'b1,7'h04,8'hA0,4'd4},
    {1'b0,7'h00,8'h22,4'd4},
    // R4: indirect write, seen directly in bank 1
    {1'b1,7'h00,8'h5A,4'd4}, {1'b1,7'h03,8'h20,4'd4},
    {1'b0,7'h20,8'h5A,4'd4},
    // R4: indirect into common window, control, pointer
    {1'b1,7'h04,8'hF5,4'd4}, {1'b0,7'h00,8'hA5,4'd4},
    {1'b1,7'h04,8'h83,4'd4}, {1'b0,7'h00,8'h20,4'd4},
    {1'b1,7'h04,8'h84,4'd4}, {1'b0,7'h00,8'h84,4'd4},
    // R5: null target reads zero, write ignored
    {1'b1,7'h04,8'h00,4'd5}, {1'b0,7'h00,8'h00,4'd5},
    {1'b1,7'h00,8'h77,4'd5}, {1'b0,7'h03,8'h20,4'd5},
    {1'b0,7'h04,8'h00,4'd5}, {1'b1,7'h04,8'h80,4'd5},
    {1'b0,7'h00,8'h00,4'd5},
    // R8: low control bits are plain storage, bank stays 0
    {1'b1,7'h03,8'h1F,4'd8}, {1'b0,7'h03,8'h1F,4'd8},
    {1'b0,7'h20,8'h11,4'd8}, {1'b0,7'h04,8'h80,4'd3}
  };

  task automatic check(input logic [7:0] exp, input int req, input string what);
    total++;
    if (rd_data !== exp) begin
      bad++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, rd_data, exp);
    end
  endtask

  // Drive at falling edge, sample just after the next rising edge.
  task automatic op(input bit we, input bit re, input logic [6:0] a,
                    input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_en = we; rd_en = re; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(8'h00, 7, "rd_data in reset");
    @(negedge clk); rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      op(VEC[i][19], !VEC[i][19], VEC[i][18:12], VEC[i][11:4]);
      if (!VEC[i][19]) check(VEC[i][11:4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R7: reset clears control only
    op(1'b1, 1'b0, 7'h04, 8'h5C);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check(8'h00, 7, "rd_data after reset");
    @(negedge clk); rst = 1'b0;
    op(1'b0, 1'b1, 7'h03, 8'h00); check(8'h00, 7, "control cleared");
    op(1'b0, 1'b1, 7'h04, 8'h00); check(8'h5C, 7, "pointer kept");
    op(1'b0, 1'b1, 7'h20, 8'h00); check(8'h11, 7, "storage kept");

    // R6: read-first on same-cycle access, then hold
    op(1'b1, 1'b0, 7'h21, 8'h01);
    op(1'b1, 1'b1, 7'h21, 8'h02); check(8'h01, 6, "read-first");
    op(1'b0, 1'b1, 7'h21, 8'h00); check(8'h02, 6, "new value");
    op(1'b1, 1'b0, 7'h21, 8'h09); check(8'h02, 6, "hold while idle");
    op(1'b0, 1'b0, 7'h03, 8'h00); check(8'h02, 6, "hold no strobe");

    // R3: pointer written from bank 3 reads back from bank 0
    op(1'b1, 1'b0, 7'h03, 8'h60);
    op(1'b1, 1'b0, 7'h04, 8'h3C);
    op(1'b1, 1'b0, 7'h03, 8'h00);
    op(1'b0, 1'b1, 7'h04, 8'h00); check(8'h3C, 3, "pointer mirror");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule